// File: doc/BRIEF.md
# Gated Pulse Counter with Serial Report

This block counts rising edges on an asynchronous pulse input over back-to-back measurement windows measured in system clocks. The window length comes out of reset at one minute of clock time and can be replaced by a host through a one-word write port. A new length takes hold at the next window boundary, so the window in progress is never cut short or stretched.

When a window closes, the block captures the running count together with a 16-bit window sequence number, and restarts counting on the same clock with no dead time. The captured pair is turned into one line of ASCII text and shifted out on a logic-level serial line, for an external level shifter to drive to a host. If a captured result is still waiting when the next window closes, the newer result replaces it and a sticky overrun flag goes high.

Top module: `pulse_tally_top`

## Requirements
- R1: The pulse input passes through a two-flop synchronizer and an edge detector; every low-to-high transition that stays high for at least one clock and low for at least one clock adds exactly one to the count.
- R2: The window length is a number of clocks, WIN_RESET after reset; a write on the configuration port changes it starting with the window that follows the current one.
- R3: At each window end the count and sequence number are captured and the counter restarts, so each report holds only the pulses of its own window (a window with no pulses reports zero).
- R4: An edge detected on the clock of a window boundary goes into the new window; over consecutive reported windows the counts sum to the number of pulses applied.
- R5: The sequence number is 0 for the first window after reset and goes up by one for every window, reported or not.
- R6: Each report line is the sequence number as 5 zero-padded decimal digits, a space (0x20), the count as 10 zero-padded decimal digits, then CR (0x0D) and LF (0x0A); digits are ASCII 0x30 to 0x39, most significant first.
- R7: Each character is framed as one low start bit, 8 data bits least significant first, and one high stop bit, each bit lasting BAUD_DIV clocks; the line rests high between characters and during reset.
- R8: If a window ends while the previous result has not yet been taken for sending, the older result is dropped (its sequence number never appears) and the overrun output goes high and stays high until reset.
- R9: The overrun output is low after reset and stays low while reports keep pace with the windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous pulse input to be counted |
| cfg_we | input | 1 | Write strobe for the window length |
| cfg_len | input | WIN_W | New window length in clocks |
| tx | output | 1 | Serial report line, idle high |
| overrun | output | 1 | Sticky flag: a result was overwritten before it was sent |

## Verification
The counter is driven with windows holding no pulse, a single pulse, and bursts of 13 and 100 pulses placed mid-window, which separates an off-by-one in edge detection from a failure to clear between windows. A continuous pulse train running across several boundaries, checked only by the sum of the reported counts, shows whether an edge landing on the boundary clock is dropped or counted twice. Very short windows force results to pile up, which tells a correct overwrite (rising sequence numbers with gaps and a sticky flag) from lost or duplicated lines, and restoring a long window checks that the length takes effect exactly at the next boundary through the sequence numbers of the final lines.

// File: rtl/pulse_tally_pkg.sv
package pulse_tally_pkg;

  typedef enum logic [1:0] {
    FMT_IDLE,
    FMT_CALC,
    FMT_SEND,
    FMT_NEXT
  } fmt_state_t;

  localparam logic [7:0] CH_ZERO  = 8'h30;
  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;

  // Decimal digits needed to print the largest value of a given bit width.
  function automatic int dec_digits(input int width);
    logic [63:0] v;
    int n;
    v = (64'd1 << width) - 64'd1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (v != 64'd0) begin
        v = v / 64'd10;
        n++;
      end
    end
    if (n == 0) n = 1;
    return n;
  endfunction

  function automatic logic [63:0] pow10(input int k);
    logic [63:0] r;
    r = 64'd1;
    for (int i = 0; i < 20; i++) begin
      if (i < k) r = r * 64'd10;
    end
    return r;
  endfunction

endpackage

// File: rtl/pt_pulse_sync.sv
module pt_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/pt_window.sv
module pt_window #(
  parameter int CNT_W = 32,
  parameter int SEQ_W = 16,
  parameter int WIN_W = 36,
  parameter logic [WIN_W-1:0] WIN_RESET = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             cfg_we,
  input  logic [WIN_W-1:0] cfg_len,
  input  logic             take,
  output logic [CNT_W-1:0] res_cnt,
  output logic [SEQ_W-1:0] res_seq,
  output logic             res_valid,
  output logic             win_end,
  output logic             overrun
);

  logic [WIN_W-1:0] len_q;   // length for the next window
  logic [WIN_W-1:0] act_q;   // length of the running window
  logic [WIN_W-1:0] tmr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEQ_W-1:0] seq_q;

  assign win_end = (act_q <= WIN_W'(1)) || (tmr_q == act_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q     <= WIN_RESET;
      act_q     <= WIN_RESET;
      tmr_q     <= '0;
      cnt_q     <= '0;
      seq_q     <= '0;
      res_cnt   <= '0;
      res_seq   <= '0;
      res_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (cfg_we) len_q <= cfg_len;
      if (win_end) begin
        tmr_q     <= '0;
        act_q     <= len_q;
        res_cnt   <= cnt_q;
        res_seq   <= seq_q;
        seq_q     <= seq_q + 1'b1;
        cnt_q     <= CNT_W'(rise);   // boundary edge belongs to the new window
        res_valid <= 1'b1;
        if (res_valid && !take) overrun <= 1'b1;
      end else begin
        tmr_q <= tmr_q + 1'b1;
        cnt_q <= cnt_q + CNT_W'(rise);
        if (take) res_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pt_report_fmt.sv
module pt_report_fmt
  import pulse_tally_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] res_cnt,
  input  logic [SEQ_W-1:0] res_seq,
  input  logic             res_valid,
  input  logic             tx_ready,
  output logic             take,
  output logic             tx_start,
  output logic [7:0]       tx_char
);

  localparam int SEQ_DIG   = dec_digits(SEQ_W);
  localparam int CNT_DIG   = dec_digits(CNT_W);
  localparam int MAX_DIG   = (CNT_DIG > SEQ_DIG) ? CNT_DIG : SEQ_DIG;
  localparam int VAL_W     = (CNT_W > SEQ_W) ? CNT_W : SEQ_W;
  localparam int CNT_FIRST = SEQ_DIG + 1;
  localparam int CR_POS    = CNT_FIRST + CNT_DIG;
  localparam int LINE_LEN  = CR_POS + 2;
  localparam int IDX_W     = $clog2(LINE_LEN);
  localparam int PIDX_W    = $clog2(MAX_DIG);

  logic [VAL_W-1:0] p10 [MAX_DIG];

  for (genvar g = 0; g < MAX_DIG; g++) begin : g_pow
    assign p10[g] = VAL_W'(pow10(g));
  end

  fmt_state_t       st_q;
  logic [IDX_W-1:0] ci_q;
  logic [VAL_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_s_q;
  logic [3:0]       dig_q;

  logic              is_dig;
  logic [PIDX_W-1:0] pidx;
  logic [7:0]        fixed_ch;
  logic [VAL_W-1:0]  cur_pow;

  always_comb begin
    is_dig   = 1'b0;
    pidx     = '0;
    fixed_ch = CH_LF;
    if (ci_q < IDX_W'(SEQ_DIG)) begin
      is_dig = 1'b1;
      pidx   = PIDX_W'(SEQ_DIG - 1 - int'(ci_q));
    end else if (ci_q == IDX_W'(SEQ_DIG)) begin
      fixed_ch = CH_SPACE;
    end else if (ci_q < IDX_W'(CR_POS)) begin
      is_dig = 1'b1;
      pidx   = PIDX_W'(CR_POS - 1 - int'(ci_q));
    end else if (ci_q == IDX_W'(CR_POS)) begin
      fixed_ch = CH_CR;
    end
  end

  assign cur_pow  = p10[pidx];
  assign take     = (st_q == FMT_IDLE) && res_valid;
  assign tx_start = (st_q == FMT_SEND) && tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= FMT_IDLE;
      ci_q    <= '0;
      rem_q   <= '0;
      cnt_s_q <= '0;
      dig_q   <= '0;
      tx_char <= CH_SPACE;
    end else begin
      case (st_q)
        FMT_IDLE: if (res_valid) begin
          rem_q   <= VAL_W'(res_seq);
          cnt_s_q <= res_cnt;
          ci_q    <= '0;
          dig_q   <= '0;
          st_q    <= FMT_CALC;
        end
        FMT_CALC: begin
          if (is_dig && rem_q >= cur_pow) begin
            rem_q <= rem_q - cur_pow;
            dig_q <= dig_q + 1'b1;
          end else begin
            tx_char <= is_dig ? (CH_ZERO + {4'b0, dig_q}) : fixed_ch;
            st_q    <= FMT_SEND;
          end
        end
        FMT_SEND: if (tx_ready) st_q <= FMT_NEXT;
        FMT_NEXT: begin
          dig_q <= '0;
          if (ci_q == IDX_W'(LINE_LEN - 1)) begin
            st_q <= FMT_IDLE;
          end else begin
            if (ci_q == IDX_W'(SEQ_DIG)) rem_q <= VAL_W'(cnt_s_q);
            ci_q <= ci_q + 1'b1;
            st_q <= FMT_CALC;
          end
        end
        default: st_q <= FMT_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_uart_tx.sv
module pt_uart_tx #(
  parameter int BAUD_DIV = 1085
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] data,
  output logic       ready,
  output logic       tx
);

  localparam int DIV_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;

  logic             busy_q;
  logic [DIV_W-1:0] div_q;
  logic [3:0]       nbit_q;
  logic [8:0]       sh_q;     // data bits then stop bit

  assign ready = ~busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      nbit_q <= '0;
      sh_q   <= '1;
      tx     <= 1'b1;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        div_q  <= '0;
        nbit_q <= '0;
        sh_q   <= {1'b1, data};
        tx     <= 1'b0;
      end
    end else if (div_q == DIV_W'(BAUD_DIV - 1)) begin
      div_q <= '0;
      if (nbit_q == 4'd9) begin
        busy_q <= 1'b0;
      end else begin
        tx     <= sh_q[0];
        sh_q   <= {1'b1, sh_q[8:1]};
        nbit_q <= nbit_q + 1'b1;
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/pulse_tally_top.sv
module pulse_tally_top #(
  parameter int CNT_W    = 32,
  parameter int SEQ_W    = 16,
  parameter int WIN_W    = 36,
  parameter int CLK_HZ   = 125000000,
  parameter int BAUD_DIV = CLK_HZ / 115200,
  parameter logic [WIN_W-1:0] WIN_RESET = WIN_W'(64'd60 * 64'(CLK_HZ))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_in,
  input  logic             cfg_we,
  input  logic [WIN_W-1:0] cfg_len,
  output logic             tx,
  output logic             overrun
);

  logic             rise_w;
  logic             win_end_w;
  logic             res_valid_w;
  logic             take_w;
  logic             tx_start_w;
  logic             tx_ready_w;
  logic [7:0]       tx_char_w;
  logic [CNT_W-1:0] res_cnt_w;
  logic [SEQ_W-1:0] res_seq_w;

  pt_pulse_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pulse_in),
    .rise     (rise_w)
  );

  pt_window #(
    .CNT_W     (CNT_W),
    .SEQ_W     (SEQ_W),
    .WIN_W     (WIN_W),
    .WIN_RESET (WIN_RESET)
  ) u_win (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise_w),
    .cfg_we    (cfg_we),
    .cfg_len   (cfg_len),
    .take      (take_w),
    .res_cnt   (res_cnt_w),
    .res_seq   (res_seq_w),
    .res_valid (res_valid_w),
    .win_end   (win_end_w),
    .overrun   (overrun)
  );

  pt_report_fmt #(
    .CNT_W (CNT_W),
    .SEQ_W (SEQ_W)
  ) u_fmt (
    .clk       (clk),
    .rst       (rst),
    .res_cnt   (res_cnt_w),
    .res_seq   (res_seq_w),
    .res_valid (res_valid_w),
    .tx_ready  (tx_ready_w),
    .take      (take_w),
    .tx_start  (tx_start_w),
    .tx_char   (tx_char_w)
  );

  pt_uart_tx #(.BAUD_DIV(BAUD_DIV)) u_uart (
    .clk   (clk),
    .rst   (rst),
    .start (tx_start_w),
    .data  (tx_char_w),
    .ready (tx_ready_w),
    .tx    (tx)
  );

endmodule

// File: rtl/pulse_tally_chk.sv
module pulse_tally_chk (
  input logic clk,
  input logic rst,
  input logic rise,
  input logic win_end,
  input logic res_valid,
  input logic take,
  input logic tx_start,
  input logic tx_ready,
  input logic tx,
  input logic overrun
);

  // R1: a synchronized edge lasts exactly one clock
  a_r1_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

  // R3: a closed window always leaves a result waiting
  a_r3_result_pending: assert property (@(posedge clk) disable iff (rst)
    win_end |=> res_valid);

  // R8: the overrun flag never drops before reset
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R8: the flag rises only when a waiting result was replaced
  a_r8_overrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(win_end && res_valid && !take));

  // R3: only a waiting result can be taken
  a_r3_take_valid: assert property (@(posedge clk) disable iff (rst)
    take |-> res_valid);

  // R7: a character starts only on an idle line and begins with a low bit
  a_r7_start_idle: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> tx_ready);

  a_r7_start_low: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx);

  // R7: the line rests high whenever the transmitter is idle
  a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> tx);

endmodule

bind pulse_tally_top pulse_tally_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rise      (rise_w),
  .win_end   (win_end_w),
  .res_valid (res_valid_w),
  .take      (take_w),
  .tx_start  (tx_start_w),
  .tx_ready  (tx_ready_w),
  .tx        (tx),
  .overrun   (overrun)
);

// File: tb/pulse_tally_top_tb_top.sv
module pulse_tally_top_tb_top;

  localparam int DIV = 4;
  localparam int L0  = 1200;
  localparam int L1  = 1000;
  localparam int LS  = 40;

  logic        clk = 1'b0;
  logic        rst;
  logic        pulse_in;
  logic        cfg_we;
  logic [35:0] cfg_len;
  logic        tx;
  logic        overrun;

  always #4 clk = ~clk;

  pulse_tally_top #(
    .BAUD_DIV  (DIV),
    .WIN_RESET (36'(L0))
  ) dut_i (
    .clk      (clk),
    .rst      (rst),
    .pulse_in (pulse_in),
    .cfg_we   (cfg_we),
    .cfg_len  (cfg_len),
    .tx       (tx),
    .overrun  (overrun)
  );

  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  bit  done = 0;

  int     n_lines = 0;
  int     l_seq [256];
  longint l_cnt [256];

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic go_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      pulse_in = 1'b1;
      @(negedge clk);
      pulse_in = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic write_len(input int len);
    cfg_len = 36'(len);
    cfg_we  = 1'b1;
    @(negedge clk);
    cfg_we  = 1'b0;
  endtask

  // Serial receiver: decodes frames and assembles report lines (R6, R7)
  initial begin : mon
    logic [7:0] lbuf [32];
    int         blen;
    logic [7:0] ch;
    blen = 0;
    forever begin
      @(negedge clk);
      if (!rst && tx === 1'b0) begin
        repeat (DIV / 2) @(negedge clk);
        chk(tx === 1'b0, "R7", "start bit level", longint'(tx), 0);
        for (int b = 0; b < 8; b++) begin
          repeat (DIV) @(negedge clk);
          ch[b] = tx;
        end
        repeat (DIV) @(negedge clk);
        chk(tx === 1'b1, "R7", "stop bit level", longint'(tx), 1);
        if (ch == 8'h0A) begin
          bit     ok;
          int     sq;
          longint cn;
          ok = (blen == 17) && (lbuf[5] == 8'h20) && (lbuf[16] == 8'h0D);
          sq = 0;
          cn = 0;
          for (int i = 0; i < 5; i++) begin
            if (lbuf[i] < 8'h30 || lbuf[i] > 8'h39) ok = 0;
            sq = sq * 10 + int'(lbuf[i] - 8'h30);
          end
          for (int i = 6; i < 16; i++) begin
            if (lbuf[i] < 8'h30 || lbuf[i] > 8'h39) ok = 0;
            cn = cn * 10 + longint'(lbuf[i] - 8'h30);
          end
          chk(ok, "R6", "report line layout", blen + 1, 18);
          if (n_lines < 256) begin
            l_seq[n_lines] = sq;
            l_cnt[n_lines] = cn;
            n_lines++;
          end
          blen = 0;
        end else if (blen < 32) begin
          lbuf[blen] = ch;
          blen++;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int  burst_n [5];
    int  p_total;
    int  gaps;
    longint sum;
    burst_n[0] = 0;
    burst_n[1] = 1;
    burst_n[2] = 13;
    burst_n[3] = 100;
    burst_n[4] = 5;

    rst      = 1'b1;
    pulse_in = 1'b0;
    cfg_we   = 1'b0;
    cfg_len  = '0;
    repeat (5) @(negedge clk);
    chk(tx === 1'b1, "R7", "line high in reset", longint'(tx), 1);
    chk(overrun === 1'b0, "R9", "overrun low in reset", longint'(overrun), 0);
    rst = 1'b0;
    go_to(3);
    chk(tx === 1'b1, "R7", "line idle after reset", longint'(tx), 1);

    // windows 0..4 at the reset length, bursts mid-window (R1, R3)
    for (int w = 0; w < 5; w++) begin
      go_to(w * L0 + 200);
      burst(burst_n[w]);
    end
    go_to(4 * L0 + 700);
    write_len(L1);   // R2: applies from window 5

    // continuous train over windows 5..7 (R4)
    p_total = 0;
    go_to(6400);
    while (cyc < 8500) begin
      pulse_in = 1'b1;
      @(negedge clk);
      pulse_in = 1'b0;
      @(negedge clk);
      @(negedge clk);
      p_total++;
    end

    go_to(8700);
    chk(overrun === 1'b0, "R9", "no overrun while keeping pace", longint'(overrun), 0);
    write_len(LS);   // short windows from 9001 force overwrites (R8)

    go_to(11000);
    write_len(L0);   // applies after the boundary at 11040
    go_to(11000 + 3 * L0);
    chk(overrun === 1'b1, "R8", "overrun set and sticky", longint'(overrun), 1);

    go_to(15800);

    chk(n_lines >= 11, "R3", "number of lines", n_lines, 11);
    if (n_lines >= 11) begin
      for (int i = 0; i < 8; i++)
        chk(l_seq[i] == i, "R5", "sequence of early window", l_seq[i], i);
      for (int i = 0; i < 5; i++)
        chk(l_cnt[i] == burst_n[i], "R1", "count of burst window", l_cnt[i], burst_n[i]);
      sum = l_cnt[5] + l_cnt[6] + l_cnt[7];
      chk(sum == p_total, "R4", "sum across boundaries", sum, p_total);
      chk(l_cnt[5] > 0 && l_cnt[6] > 0 && l_cnt[7] > 0, "R4", "train seen in each window",
          l_cnt[6], 1);
      gaps = 0;
      for (int i = 8; i < n_lines; i++) begin
        chk(l_seq[i] > l_seq[i-1], "R8", "sequence strictly rising", l_seq[i], l_seq[i-1] + 1);
        chk(l_cnt[i] == 0, "R3", "empty window reports zero", l_cnt[i], 0);
        if (l_seq[i] > l_seq[i-1] + 1) gaps++;
      end
      chk(gaps > 0, "R8", "dropped results leave gaps", gaps, 1);
      chk(l_seq[n_lines-1] == 61, "R2", "last window after restore", l_seq[n_lines-1], 61);
      chk(l_seq[n_lines-2] == 60, "R2", "second last window", l_seq[n_lines-2], 60);
      chk(l_seq[n_lines-3] == 59, "R5", "first restored window", l_seq[n_lines-3], 59);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule